// File: doc/BRIEF.md
# LVDS display link deserializer

This block rebuilds the parallel pixel word of a flat-panel display link from four serial lanes: three data lanes and one lane that carries the pixel-rate clock. An upstream sampler delivers one bit per lane on every cycle of a bit clock running at seven times the pixel rate. The block shifts those samples in and finds the 7-bit word boundary by looking for a fixed pattern on the clock lane. It then splits each recovered 21-bit word into three 6-bit colour components and three timing controls: line sync, frame sync and data enable.

The block produces a pixel clock from its bit-slot counter. The falling edge of this clock is the strobe for the parallel outputs, and each new word is already on the outputs when that edge arrives. The block only takes in words after it has seen the boundary pattern in the same place on several periods in a row. It keeps that lock through a single bad period. When the active-low power-down input is low, all parallel outputs and the pixel clock hold their last values, while lock tracking keeps running.

Top module: `lvds_pixel_deser`

## Requirements
- R1: Each data lane carries 7 bits per pixel period, most significant bit first. Lane 0 fills word bits 6:0, lane 1 fills bits 13:7 and lane 2 fills bits 20:14. The first bit a lane delivers in a period lands in the top bit of that lane's range.
- R2: The output fields are taken from the recovered word as follows: red = bits 5:0, green = bits 11:6, blue = bits 17:12, line sync = bit 18, frame sync = bit 19, data enable = bit 20.
- R3: The clock-lane window is the last 7 samples, with the oldest sample as the MSB. The word boundary is the sample that completes the window 1100011. Lock is declared after 3 consecutive periods, 7 cycles apart, that end on a matching window, and `link_locked` goes high in the cycle after the third match.
- R4: While locked, one period that ends on a mismatching window keeps lock. Two consecutive mismatching periods drop lock in the cycle after the second one.
- R5: A word is taken in only at a boundary where lock was already held and power-down is high. It becomes visible in the cycle after the last bit of its period. At all other times the fields hold their value, including before lock and after lock is lost.
- R6: While power-down is high, `px_clk` is high for bit slots 0 to 3 and low for slots 4 to 6. Slot 0 is the cycle in which a new word appears, so the falling edge comes 4 cycles after each update.
- R7: While power-down is low, the colour fields, the control bits and `px_clk` keep their previous values. Boundary search and lock tracking continue.
- R8: Reset sets all output fields, `px_clk` and `link_locked` to 0. Power-down does not clear anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down; low freezes the outputs |
| rx_lane | input | 3 | One sample from each data lane per bit clock |
| rx_clk_lane | input | 1 | One sample from the forwarded clock lane per bit clock |
| px_red | output | 6 | Red component |
| px_grn | output | 6 | Green component |
| px_blu | output | 6 | Blue component |
| px_hsync | output | 1 | Line sync |
| px_vsync | output | 1 | Frame sync |
| px_de | output | 1 | Data enable |
| px_clk | output | 1 | Recovered pixel clock; its falling edge strobes the data |
| link_locked | output | 1 | Word boundary is locked |

## Verification
The stream starts with a run of idle zero bits, so the boundary falls at an arbitrary phase of the bit-slot counter. A single bit set in one lane separates lane order and bit order from field mapping. All-ones, alternating-bit and walking patterns expose swapped or shifted fields. Clock-lane patterns with one corrupted bit are sent once and twice in a row, which shows whether the block tolerates a single miss, drops lock on the second, and then holds the outputs until it relocks. A period sent with power-down low carries fresh data, and the outputs must not change.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;
    localparam int SER_RATIO      = 7;
    localparam int DATA_LANES     = 3;
    localparam int COLOR_W        = 6;
    localparam int LOCK_HITS      = 3;
    localparam int LOSE_MISSES    = 2;
    localparam int CLK_HIGH_SLOTS = 4;
    localparam logic [SER_RATIO-1:0] CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/lane_shifter.sv
// Shifts one lane in, oldest sample at the MSB. The window includes the
// sample arriving this cycle.
module lane_shifter #(
    parameter int SER_RATIO = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din,
    output logic [SER_RATIO-1:0] window
);
    logic [SER_RATIO-1:0] sr_d, sr_q;

    always_comb begin
        sr_d   = {sr_q[SER_RATIO-2:0], din};
        window = sr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end
endmodule

// File: rtl/frame_aligner.sv
// Bit-slot counter, boundary search and lock tracking, and pixel clock.
module frame_aligner #(
    parameter int SER_RATIO      = 7,
    parameter int LOCK_HITS      = 3,
    parameter int LOSE_MISSES    = 2,
    parameter int CLK_HIGH_SLOTS = 4,
    parameter logic [SER_RATIO-1:0] CLK_PATTERN = 7'b1100011,
    localparam int SLOT_W = $clog2(SER_RATIO)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_n,
    input  logic [SER_RATIO-1:0] ck_window,
    output logic [SLOT_W-1:0]    slot,
    output logic                 locked,
    output logic                 capture,
    output logic                 pix_clk
);
    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(LOSE_MISSES + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SER_RATIO - 1);
    localparam logic [SLOT_W-1:0] HIGH_SLOTS = SLOT_W'(CLK_HIGH_SLOTS);
    localparam logic [HIT_W-1:0]  HIT_LAST   = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST  = MISS_W'(LOSE_MISSES - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [HIT_W-1:0]  hits;
        logic [MISS_W-1:0] misses;
        logic              locked;
        logic              pclk;
    } align_t;

    align_t st_d, st_q;
    logic   at_edge, match;

    always_comb begin
        st_d    = st_q;
        at_edge = (st_q.slot == LAST_SLOT);
        match   = (ck_window == CLK_PATTERN);
        st_d.slot = at_edge ? '0 : st_q.slot + 1'b1;

        if (!st_q.locked) begin
            if (st_q.hits == '0) begin
                // hunting: any phase may start a candidate boundary
                if (match) begin
                    st_d.slot = '0;
                    st_d.hits = HIT_W'(1);
                end
            end else if (at_edge) begin
                if (!match) begin
                    st_d.hits = '0;
                end else if (st_q.hits == HIT_LAST) begin
                    st_d.locked = 1'b1;
                    st_d.hits   = '0;
                end else begin
                    st_d.hits = st_q.hits + 1'b1;
                end
            end
        end else if (at_edge) begin
            if (match) begin
                st_d.misses = '0;
            end else if (st_q.misses == MISS_LAST) begin
                st_d.locked = 1'b0;
                st_d.misses = '0;
            end else begin
                st_d.misses = st_q.misses + 1'b1;
            end
        end

        st_d.pclk = pwr_n ? (st_d.slot < HIGH_SLOTS) : st_q.pclk;
        capture   = at_edge && st_q.locked && pwr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot    = st_q.slot;
    assign locked  = st_q.locked;
    assign pix_clk = st_q.pclk;
endmodule

// File: rtl/word_mapper.sv
// Splits the recovered word into colour components and controls.
module word_mapper #(
    parameter int COLOR_W = 6,
    localparam int WORD_W = 3 * COLOR_W + 3
) (
    input  logic [WORD_W-1:0]  word,
    output logic [COLOR_W-1:0] red,
    output logic [COLOR_W-1:0] grn,
    output logic [COLOR_W-1:0] blu,
    output logic               hsync,
    output logic               vsync,
    output logic               de
);
    localparam int GRN_LO = COLOR_W;
    localparam int BLU_LO = 2 * COLOR_W;
    localparam int CTL_LO = 3 * COLOR_W;

    always_comb begin
        red   = word[COLOR_W-1:0];
        grn   = word[GRN_LO +: COLOR_W];
        blu   = word[BLU_LO +: COLOR_W];
        hsync = word[CTL_LO];
        vsync = word[CTL_LO+1];
        de    = word[CTL_LO+2];
    end
endmodule

// File: rtl/lvds_pixel_deser.sv
module lvds_pixel_deser
    import lvds_deser_pkg::*;
#(
    parameter int P_SER_RATIO      = SER_RATIO,
    parameter int P_DATA_LANES     = DATA_LANES,
    parameter int P_COLOR_W        = COLOR_W,
    parameter int P_LOCK_HITS      = LOCK_HITS,
    parameter int P_LOSE_MISSES    = LOSE_MISSES,
    parameter int P_CLK_HIGH_SLOTS = CLK_HIGH_SLOTS,
    parameter logic [P_SER_RATIO-1:0] P_CLK_PATTERN = CLK_PATTERN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_n,
    input  logic [P_DATA_LANES-1:0] rx_lane,
    input  logic                    rx_clk_lane,
    output logic [P_COLOR_W-1:0]    px_red,
    output logic [P_COLOR_W-1:0]    px_grn,
    output logic [P_COLOR_W-1:0]    px_blu,
    output logic                    px_hsync,
    output logic                    px_vsync,
    output logic                    px_de,
    output logic                    px_clk,
    output logic                    link_locked
);
    localparam int WORD_W = P_SER_RATIO * P_DATA_LANES;
    localparam int SLOT_W = $clog2(P_SER_RATIO);

    logic [P_SER_RATIO-1:0] lane_win [P_DATA_LANES];
    logic [P_SER_RATIO-1:0] ck_win;
    logic [WORD_W-1:0]      assembled;
    logic [WORD_W-1:0]      word_d, word_q;
    logic [SLOT_W-1:0]      slot_w;
    logic                   capture_w;

    for (genvar l = 0; l < P_DATA_LANES; l++) begin : g_lane
        lane_shifter #(.SER_RATIO(P_SER_RATIO)) shf_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (rx_lane[l]),
            .window (lane_win[l])
        );
        assign assembled[l*P_SER_RATIO +: P_SER_RATIO] = lane_win[l];
    end

    lane_shifter #(.SER_RATIO(P_SER_RATIO)) ck_shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (rx_clk_lane),
        .window (ck_win)
    );

    frame_aligner #(
        .SER_RATIO      (P_SER_RATIO),
        .LOCK_HITS      (P_LOCK_HITS),
        .LOSE_MISSES    (P_LOSE_MISSES),
        .CLK_HIGH_SLOTS (P_CLK_HIGH_SLOTS),
        .CLK_PATTERN    (P_CLK_PATTERN)
    ) algn_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_n     (pwr_n),
        .ck_window (ck_win),
        .slot      (slot_w),
        .locked    (link_locked),
        .capture   (capture_w),
        .pix_clk   (px_clk)
    );

    always_comb begin
        word_d = capture_w ? assembled : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    word_mapper #(.COLOR_W(P_COLOR_W)) map_i (
        .word  (word_q),
        .red   (px_red),
        .grn   (px_grn),
        .blu   (px_blu),
        .hsync (px_hsync),
        .vsync (px_vsync),
        .de    (px_de)
    );
endmodule

// File: rtl/lvds_pixel_deser_chk.sv
module lvds_pixel_deser_chk #(
    parameter int SER_RATIO      = 7,
    parameter int WORD_W         = 21,
    parameter int CLK_HIGH_SLOTS = 4,
    parameter logic [SER_RATIO-1:0] CLK_PATTERN = 7'b1100011,
    localparam int SLOT_W = $clog2(SER_RATIO)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pwr_n,
    input logic                 locked,
    input logic [SLOT_W-1:0]    slot,
    input logic [SER_RATIO-1:0] ck_window,
    input logic [WORD_W-1:0]    word,
    input logic                 pix_clk
);
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SER_RATIO - 1);
    localparam logic [SLOT_W-1:0] HIGH_SLOTS = SLOT_W'(CLK_HIGH_SLOTS);

    assert_slot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST_SLOT);

    assert_lock_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(slot) == LAST_SLOT && $past(ck_window) == CLK_PATTERN));

    assert_drop_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(slot) == LAST_SLOT && $past(ck_window) != CLK_PATTERN));

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && slot == LAST_SLOT && pwr_n) |=> $stable(word));

    assert_clk_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_n |=> (pix_clk == (slot < HIGH_SLOTS)));

    assert_pwrdn_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> ($stable(word) && $stable(pix_clk)));
endmodule

bind lvds_pixel_deser lvds_pixel_deser_chk #(
    .SER_RATIO      (P_SER_RATIO),
    .WORD_W         (P_SER_RATIO * P_DATA_LANES),
    .CLK_HIGH_SLOTS (P_CLK_HIGH_SLOTS),
    .CLK_PATTERN    (P_CLK_PATTERN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_n     (pwr_n),
    .locked    (link_locked),
    .slot      (slot_w),
    .ck_window (ck_win),
    .word      (word_q),
    .pix_clk   (px_clk)
);

// File: tb/lvds_pixel_deser_tb_top.sv
module lvds_pixel_deser_tb_top;
    localparam logic [6:0] GOOD = 7'b1100011;
    localparam logic [6:0] BAD  = 7'b1100010;

    logic       clk = 1'b0;
    logic       rst_n, pwr_n, rx_clk_lane;
    logic [2:0] rx_lane;
    logic [5:0] px_red, px_grn, px_blu;
    logic       px_hsync, px_vsync, px_de, px_clk, link_locked;

    always #10 clk = ~clk;

    lvds_pixel_deser dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .rx_lane(rx_lane),
        .rx_clk_lane(rx_clk_lane), .px_red(px_red), .px_grn(px_grn),
        .px_blu(px_blu), .px_hsync(px_hsync), .px_vsync(px_vsync),
        .px_de(px_de), .px_clk(px_clk), .link_locked(link_locked)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    // behavioural reference
    int          m_phase, m_hits, m_miss, ck_hist;
    int          ln_hist [3];
    bit          m_lock, m_pclk;
    logic [20:0] m_word;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [20:0] dut_word();
        return {px_de, px_vsync, px_hsync, px_blu, px_grn, px_red};
    endfunction

    task automatic model_reset();
        m_phase = 0; m_hits = 0; m_miss = 0; ck_hist = 0;
        m_lock = 0; m_pclk = 0; m_word = '0;
        for (int l = 0; l < 3; l++) ln_hist[l] = 0;
    endtask

    task automatic model_step(bit ck, bit [2:0] d, bit pw);
        bit boundary, seen;
        int next_phase;
        ck_hist = ((ck_hist << 1) | int'(ck)) % 128;
        for (int l = 0; l < 3; l++) ln_hist[l] = ((ln_hist[l] << 1) | int'(d[l])) % 128;
        boundary = (m_phase == 6);
        seen     = (ck_hist == 99);  // 1100011
        if (boundary && m_lock && pw)
            m_word = 21'(ln_hist[2] * 16384 + ln_hist[1] * 128 + ln_hist[0]);
        next_phase = (m_phase + 1) % 7;
        if (!m_lock) begin
            if (m_hits == 0) begin
                if (seen) begin next_phase = 0; m_hits = 1; end
            end else if (boundary) begin
                m_hits = seen ? m_hits + 1 : 0;
                if (m_hits == 3) begin m_lock = 1; m_hits = 0; end
            end
        end else if (boundary) begin
            m_miss = seen ? 0 : m_miss + 1;
            if (m_miss == 2) begin m_lock = 0; m_miss = 0; end
        end
        m_phase = next_phase;
        if (pw) m_pclk = (m_phase < 4);
    endtask

    // drive one bit per lane at a negedge, then compare at the next negedge
    task automatic tick(bit ck, bit [2:0] d, bit pw);
        rx_clk_lane = ck; rx_lane = d; pwr_n = pw;
        model_step(ck, d, pw);
        @(negedge clk);
        check("R1 R2 R5", "word", 32'(dut_word()), 32'(m_word));
        check("R6", "px_clk", 32'(px_clk), 32'(m_pclk));
        check("R3 R4", "link_locked", 32'(link_locked), 32'(m_lock));
    endtask

    task automatic send_pixel(logic [20:0] w, logic [6:0] pat, bit pw);
        for (int k = 0; k < 7; k++) begin
            bit [2:0] d;
            for (int l = 0; l < 3; l++) d[l] = w[l*7 + 6 - k];
            tick(pat[6-k], d, pw);
        end
    endtask

    task automatic check_fields(string req, logic [20:0] w);
        check(req, "red",   32'(px_red),   32'(w[5:0]));
        check(req, "green", 32'(px_grn),   32'(w[11:6]));
        check(req, "blue",  32'(px_blu),   32'(w[17:12]));
        check(req, "hsync", 32'(px_hsync), 32'(w[18]));
        check(req, "vsync", 32'(px_vsync), 32'(w[19]));
        check(req, "de",    32'(px_de),    32'(w[20]));
    endtask

    initial begin
        rst_n = 1'b0; pwr_n = 1'b1; rx_lane = '0; rx_clk_lane = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check_fields("R8", 21'h0);
        check("R8", "px_clk", 32'(px_clk), 32'h0);
        check("R8", "link_locked", 32'(link_locked), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 3; i++) tick(1'b0, 3'b000, 1'b1);

        send_pixel(21'h1FFFFF, GOOD, 1'b1);
        send_pixel(21'h155555, GOOD, 1'b1);
        check("R3", "not locked after two matches", 32'(link_locked), 32'h0);
        send_pixel(21'h0AAAAA, GOOD, 1'b1);
        check("R3", "locked after three matches", 32'(link_locked), 32'h1);
        check_fields("R5", 21'h0);  // nothing taken before lock

        // lane 1, first bit only -> word bit 13 -> blue bit 1
        send_pixel(21'h002000, GOOD, 1'b1);
        check("R1", "lane1 msb lands in blue[1]", 32'(px_blu), 32'h2);
        check("R6", "clock high at update", 32'(px_clk), 32'h1);
        send_pixel(21'h1C0F3A, GOOD, 1'b1);
        check_fields("R2", 21'h1C0F3A);
        send_pixel(21'h1FFFFF, GOOD, 1'b1);
        check_fields("R2", 21'h1FFFFF);
        send_pixel(21'h0AAAAA, GOOD, 1'b1);
        check_fields("R1", 21'h0AAAAA);
        for (int b = 0; b < 21; b += 5) send_pixel(21'(1) << b, GOOD, 1'b1);
        check_fields("R1", 21'h100000);

        // power-down freezes outputs, lock continues
        send_pixel(21'h0123AB, GOOD, 1'b0);
        check_fields("R7", 21'h100000);
        check("R7", "lock kept in power-down", 32'(link_locked), 32'h1);
        send_pixel(21'h0123AB, GOOD, 1'b1);
        check_fields("R7", 21'h0123AB);

        // single miss tolerated
        send_pixel(21'h155555, BAD, 1'b1);
        check("R4", "single miss keeps lock", 32'(link_locked), 32'h1);
        send_pixel(21'h0F0F0F, GOOD, 1'b1);
        check_fields("R4", 21'h0F0F0F);

        // two misses drop lock
        send_pixel(21'h012345, BAD, 1'b1);
        send_pixel(21'h054321, BAD, 1'b1);
        check("R4", "two misses drop lock", 32'(link_locked), 32'h0);
        send_pixel(21'h1ABCDE, GOOD, 1'b1);
        check_fields("R5", 21'h054321);
        send_pixel(21'h1ABCDE, GOOD, 1'b1);
        send_pixel(21'h1ABCDE, GOOD, 1'b1);
        check("R3", "relocked", 32'(link_locked), 32'h1);
        check_fields("R5", 21'h054321);
        send_pixel(21'h07E03F, GOOD, 1'b1);
        check_fields("R2", 21'h07E03F);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1..R8 actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule